// File: doc/BRIEF.md
# Match Address Encoder with Multi-Hit Flags

This block turns the match lines of a content-addressable memory into a result the rest of the array can use. Each entry of the memory drives one hit bit. The block gives back a binary address for the selected hit, and two flags. One flag says that exactly one entry hit. The other says that more than one entry hit. With a single unit doing both the validity check and the priority choice, the parent array needs only one submodule to resolve its lookups.

The block is purely combinational and has no clock or reset. All outputs follow the hit vector within the same cycle. The parent array registers or gates the outputs as it needs. When several entries hit, the lowest-numbered one is selected, and the multi-hit flag lets the consumer treat the address as a tie-break result rather than a unique answer. The hit vector and the results are plain status signals, so there is no handshake: a new vector may be applied in any cycle.

Top module: `cam_hit_encoder`

## Requirements
- R1: The entry count is the parameter NUM_ENTRIES. The address output is ceil(log2(NUM_ENTRIES)) bits wide, and at least 1 bit wide. With the default of 16 entries it is 4 bits.
- R2: When no hit bit is set, hit_single, hit_multi and hit_addr are all 0.
- R3: When exactly one hit bit is set, hit_single is 1, hit_multi is 0, and hit_addr equals the index of that bit.
- R4: When two or more hit bits are set, hit_multi is 1 and hit_single is 0.
- R5: Whenever at least one hit bit is set, the hit bit at index hit_addr is set. This also holds when several bits are set.
- R6: When several hit bits are set, hit_addr is the lowest index whose bit is set. Bit 0 has the highest priority.
- R7: The outputs depend only on the present hit vector, with no clock. A changed vector is reflected at the outputs within the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| hit_vec | input | NUM_ENTRIES | One match bit per entry; bit i is entry i |
| hit_addr | output | ADDR_W | Index of the lowest-numbered set hit bit, or 0 when there is no hit |
| hit_single | output | 1 | Exactly one hit bit is set |
| hit_multi | output | 1 | Two or more hit bits are set |

## Verification
The assertions run whenever the hit vector changes. They check the following on every vector:
- the flags against the population count of the vector;
- the no-hit output state;
- that the reported address points at a set bit;
- that no set bit lies below that address.

Only the bench scenarios can show the rest. These are the exact address for every single-hot position, the behaviour at the extreme positions (bit 0, the top bit, all bits set), the output width, and that the outputs follow a new vector with no clock edge in between.

// File: rtl/cam_hit_pkg.sv
package cam_hit_pkg;

  // Classification of a hit vector by its number of set bits.
  typedef enum logic [1:0] {
    HIT_NONE = 2'd0,
    HIT_ONE  = 2'd1,
    HIT_MANY = 2'd2
  } hit_class_e;

  // Width of an index into n entries, never less than one bit.
  function automatic int unsigned index_width(input int unsigned n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

endpackage

// File: rtl/cam_hit_prio_sel.sv
// Lowest-index selector: scans the hit vector and returns the index of the
// first set bit, plus a flag that any bit was set.
module cam_hit_prio_sel #(
  parameter int unsigned NUM_ENTRIES = 16,
  localparam int unsigned ADDR_W = cam_hit_pkg::index_width(NUM_ENTRIES)
) (
  input  logic [NUM_ENTRIES-1:0] hits,
  output logic [ADDR_W-1:0]      sel_idx,
  output logic                   any_hit
);

  always_comb begin
    sel_idx = '0;
    any_hit = 1'b0;
    for (int i = 0; i < int'(NUM_ENTRIES); i++) begin
      if (hits[i] && !any_hit) begin
        sel_idx = i[ADDR_W-1:0];
        any_hit = 1'b1;
      end
    end
  end

endmodule

// File: rtl/cam_hit_classify.sv
// Population classifier: none, exactly one, or several hits. Clearing the
// lowest set bit leaves a nonzero remainder only when two or more bits are set.
module cam_hit_classify #(
  parameter int unsigned NUM_ENTRIES = 16
) (
  input  logic [NUM_ENTRIES-1:0] hits,
  output cam_hit_pkg::hit_class_e hit_class
);
  import cam_hit_pkg::*;

  localparam logic [NUM_ENTRIES-1:0] ONE = NUM_ENTRIES'(1);

  logic [NUM_ENTRIES-1:0] remainder;
  logic                   some;
  logic                   several;

  always_comb begin
    remainder = hits & (hits - ONE);
    some      = |hits;
    several   = |remainder;
    if (!some)
      hit_class = HIT_NONE;
    else if (several)
      hit_class = HIT_MANY;
    else
      hit_class = HIT_ONE;
  end

endmodule

// File: rtl/cam_hit_encoder.sv
// Match address encoder: merges one-hot validity checking with lowest-index
// priority selection for the hit lines of a content-addressable memory.
module cam_hit_encoder #(
  parameter int unsigned NUM_ENTRIES = 16,
  localparam int unsigned ADDR_W = cam_hit_pkg::index_width(NUM_ENTRIES)
) (
  input  logic [NUM_ENTRIES-1:0] hit_vec,
  output logic [ADDR_W-1:0]      hit_addr,
  output logic                   hit_single,
  output logic                   hit_multi
);
  import cam_hit_pkg::*;

  logic [ADDR_W-1:0] sel_idx;
  logic              any_hit;
  hit_class_e        hit_class;

  cam_hit_prio_sel #(
    .NUM_ENTRIES(NUM_ENTRIES)
  ) u_prio (
    .hits    (hit_vec),
    .sel_idx (sel_idx),
    .any_hit (any_hit)
  );

  cam_hit_classify #(
    .NUM_ENTRIES(NUM_ENTRIES)
  ) u_class (
    .hits      (hit_vec),
    .hit_class (hit_class)
  );

  always_comb begin
    hit_single = 1'b0;
    hit_multi  = 1'b0;
    case (hit_class)
      HIT_ONE:  hit_single = 1'b1;
      HIT_MANY: hit_multi  = 1'b1;
      default:  ;
    endcase
    hit_addr = any_hit ? sel_idx : '0;
  end

  // Checks on every settled vector.
  logic [NUM_ENTRIES-1:0] below_mask;
  always_comb begin
    for (int i = 0; i < int'(NUM_ENTRIES); i++)
      below_mask[i] = (i < int'(hit_addr));
  end

  always_comb begin
    AST_NO_HIT_ZERO: assert ((hit_vec != '0) ||
                             (!hit_single && !hit_multi && hit_addr == '0))
      else $error("no-hit outputs not zero"); // R2
    AST_SINGLE_FLAG: assert (hit_single == ($countones(hit_vec) == 1))
      else $error("single flag disagrees with population"); // R3
    AST_MULTI_FLAG: assert (hit_multi == ($countones(hit_vec) > 1))
      else $error("multi flag disagrees with population"); // R4
    AST_FLAGS_EXCL: assert (!(hit_single && hit_multi))
      else $error("both flags set"); // R4
    AST_ADDR_ON_HIT: assert ((hit_vec == '0) || hit_vec[hit_addr])
      else $error("address points at a clear bit"); // R5
    AST_ADDR_LOWEST: assert ((hit_vec & below_mask) == '0)
      else $error("a set bit lies below the address"); // R6
  end

endmodule

// File: tb/cam_hit_encoder_tb.sv
module cam_hit_encoder_tb;
  localparam int unsigned N  = 16;
  localparam int unsigned AW = (N > 1) ? $clog2(N) : 1;

  logic          clk = 1'b0;
  logic [N-1:0]  hit_vec = '0;
  logic [AW-1:0] hit_addr;
  logic          hit_single;
  logic          hit_multi;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk; // 250 MHz

  cam_hit_encoder #(.NUM_ENTRIES(N)) u_dut (
    .hit_vec    (hit_vec),
    .hit_addr   (hit_addr),
    .hit_single (hit_single),
    .hit_multi  (hit_multi)
  );

  function automatic int ref_lowest(input logic [N-1:0] v);
    for (int i = 0; i < int'(N); i++) if (v[i]) return i;
    return 0;
  endfunction

  function automatic int ref_pop(input logic [N-1:0] v);
    int c = 0;
    for (int i = 0; i < int'(N); i++) c += int'(v[i]);
    return c;
  endfunction

  task automatic check(input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // Apply at the falling edge, then sample 1 ns later with no clock edge between.
  task automatic apply_and_check(input logic [N-1:0] v, input string req);
    int pop;
    @(negedge clk);
    hit_vec = v;
    #1;
    pop = ref_pop(v);
    check(req, "single", int'(hit_single), (pop == 1) ? 1 : 0);
    check(req, "multi",  int'(hit_multi),  (pop > 1) ? 1 : 0);
    check(req, "addr",   int'(hit_addr),   (pop == 0) ? 0 : ref_lowest(v));
  endtask

  initial begin
    logic [N-1:0] v;
    void'($urandom(32'd20240611));
    check("R1", "addr width", $bits(hit_addr), 4);
    apply_and_check('0, "R2");
    for (int i = 0; i < int'(N); i++) apply_and_check(N'(1) << i, "R3");
    apply_and_check('1, "R4 R6");
    apply_and_check(N'(3) << (N - 2), "R4 R6");
    apply_and_check((N'(1) << (N - 1)) | N'(1), "R5 R6");
    // R7: switch between vectors without a clock edge between them
    hit_vec = N'(1) << 5;
    #0.5;
    hit_vec = N'(1) << 9;
    #0.5;
    check("R7", "addr follows", int'(hit_addr), 9);
    for (int k = 0; k < 300; k++) begin
      v = N'($urandom);
      if (ref_pop(v) < 2) begin
        v[$urandom % N] = 1'b1;
        v[$urandom % N] = 1'b1;
        if (ref_pop(v) < 2) v = v | N'(1) << (N - 1) | N'(1) << 1;
      end
      apply_and_check(v, "R4 R5 R6");
    end
    apply_and_check('0, "R2");
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule